// File: doc/BRIEF.md
# Integer and Fractional 8x8 Multiplier

This block multiplies two 8-bit operands and returns a 16-bit product, split into a low byte and a high byte, together with a zero flag and a carry flag. The product is meant for a fixed register pair: the low byte goes to register 0 and the high byte to register 1. A 3-bit mode code picks both the operand signedness and the number format. The unsigned, signed and mixed-sign products can each be taken as plain integers or as 1.7 fixed-point fractions. In the fractional formats the product is shifted left by one place.

The surrounding core fetches the operands and decodes the instruction. The block receives operand values and the mode code along with a one-cycle `start` strobe. The arithmetic is combinational, and the result is registered. One clock later, `done` is high for a single cycle and the outputs carry the result. The outputs keep their value until the next `start`.

Fractional results have one property that callers must know. The carry flag comes from bit 15 of the product before the shift, while the zero flag tests the 16-bit value after the shift.

Top module: `mulx_unit`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after its release, `done`, `prod_lo`, `prod_hi`, `flag_z` and `flag_c` are all 0.
- R2: A `start` sampled high at a rising edge gives `done` = 1 right after that edge. `done` is 0 after any edge where `start` was low.
- R3: After an edge where `start` was low, `prod_lo`, `prod_hi`, `flag_z` and `flag_c` keep their previous values.
- R4: Mode field encoding. Bit 2 set selects the fractional format. Bits 1:0 select signedness: 00 is unsigned×unsigned, 01 is signed×signed, 10 is signed×unsigned. With bits 1:0 = 00 the result is the unsigned product of `op_a` and `op_b`, with the high byte on `prod_hi` and the low byte on `prod_lo`.
- R5: With bits 1:0 = 01, both operands are read as two's complement, and the 16-bit product is sign-extended correctly.
- R6: With bits 1:0 = 10, `op_a` is read as two's complement and `op_b` as unsigned.
- R7: With bit 2 set, `{prod_hi,prod_lo}` is the selected product shifted left by one place, so `prod_lo[0]` is 0.
- R8: In the integer formats (bit 2 clear), `flag_c` equals bit 15 of the product, and `flag_z` is 1 exactly when the 16-bit product is zero.
- R9: In the fractional formats, `flag_c` equals bit 15 of the product before the shift, and `flag_z` is 1 exactly when the shifted 16-bit result is zero.
- R10: Bits 1:0 = 11 is a reserved code and behaves exactly like 00 (unsigned×unsigned), in both the integer and the fractional format.
- R11: Fractional signed×signed with 0x80 × 0x80 (−1.0 × −1.0) gives 0x8000, with `flag_c` = 0 and `flag_z` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Operands and mode are valid this cycle |
| mode | input | 3 | Bit 2: fractional; bits 1:0: signedness select |
| op_a | input | 8 | First operand (signed in modes 01 and 10) |
| op_b | input | 8 | Second operand (signed in mode 01 only) |
| done | output | 1 | Result registered this cycle (one-cycle pulse) |
| prod_lo | output | 8 | Low byte of the result (register 0) |
| prod_hi | output | 8 | High byte of the result (register 1) |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag |

## Verification
The assertions check four timing and structural properties on every cycle. `done` appears exactly one cycle after `start`, and the outputs hold whenever `start` is low. Fractional results always have a clear least significant bit, and the integer carry always equals the top result bit. The arithmetic itself can only be shown by the bench's scenarios: sign handling in each signedness mode, the reserved code, the carry taken before the shift, and the −1.0 × −1.0 wrap. The bench compares these against products it computes on its own.

// File: rtl/mulx_pkg.sv
package mulx_pkg;

    // Signedness select, mode bits 1:0
    typedef enum logic [1:0] {
        SEL_UU  = 2'b00,
        SEL_SS  = 2'b01,
        SEL_SU  = 2'b10,
        SEL_RSV = 2'b11
    } sel_e;

    localparam int MODE_W   = 3;
    localparam int FRAC_BIT = 2;

endpackage

// File: rtl/mulx_sext.sv
module mulx_sext #(
    parameter int W = 8
) (
    input  logic [W-1:0]   val,
    input  logic           is_signed,
    output logic [2*W-1:0] ext
);
    localparam int EXT_W = 2 * W;

    logic fill;

    always_comb begin
        fill = is_signed & val[W-1];
    end

    genvar i;
    generate
        for (i = 0; i < EXT_W; i++) begin : g_bit
            if (i < W) begin : g_lo
                assign ext[i] = val[i];
            end else begin : g_hi
                assign ext[i] = fill;
            end
        end
    endgenerate

endmodule

// File: rtl/mulx_datapath.sv
module mulx_datapath
    import mulx_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [MODE_W-1:0] mode,
    input  logic [W-1:0]      a,
    input  logic [W-1:0]      b,
    output logic [2*W-1:0]    result,
    output logic              z,
    output logic              c
);
    localparam int PW = 2 * W;

    sel_e          sel;
    logic          frac;
    logic          a_sgn;
    logic          b_sgn;
    logic [PW-1:0] a_x;
    logic [PW-1:0] b_x;
    logic [PW-1:0] raw;

    always_comb begin
        sel   = sel_e'(mode[1:0]);
        frac  = mode[FRAC_BIT];
        a_sgn = (sel == SEL_SS) || (sel == SEL_SU);
        b_sgn = (sel == SEL_SS);
    end

    mulx_sext #(.W(W)) u_ext_a (.val(a), .is_signed(a_sgn), .ext(a_x));
    mulx_sext #(.W(W)) u_ext_b (.val(b), .is_signed(b_sgn), .ext(b_x));

    // Multiplying the sign-extended operands modulo 2^PW gives the exact
    // two's-complement product for every signedness mix.
    always_comb begin
        raw    = a_x * b_x;
        result = frac ? {raw[PW-2:0], 1'b0} : raw;
        c      = raw[PW-1];
        z      = (result == '0);
    end

endmodule

// File: rtl/mulx_unit.sv
module mulx_unit
    import mulx_pkg::*;
#(
    parameter int W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [MODE_W-1:0] mode,
    input  logic [W-1:0]      op_a,
    input  logic [W-1:0]      op_b,
    output logic              done,
    output logic [W-1:0]      prod_lo,
    output logic [W-1:0]      prod_hi,
    output logic              flag_z,
    output logic              flag_c
);
    localparam int PW = 2 * W;

    typedef struct packed {
        logic          done;
        logic          frac;
        logic [PW-1:0] prod;
        logic          z;
        logic          c;
    } state_t;

    state_t        st_d, st_q;
    logic [PW-1:0] res_w;
    logic          z_w, c_w;

    mulx_datapath #(.W(W)) u_dp (
        .mode   (mode),
        .a      (op_a),
        .b      (op_b),
        .result (res_w),
        .z      (z_w),
        .c      (c_w)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = start;
        if (start) begin
            st_d.frac = mode[FRAC_BIT];
            st_d.prod = res_w;
            st_d.z    = z_w;
            st_d.c    = c_w;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        done    = st_q.done;
        prod_lo = st_q.prod[W-1:0];
        prod_hi = st_q.prod[PW-1:W];
        flag_z  = st_q.z;
        flag_c  = st_q.c;
    end

    // R2: the strobe follows a start by one cycle
    a_r2_done_follows_start: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> done);
    a_r2_done_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> !done);

    // R3: idle cycles leave the result untouched
    a_r3_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> $stable({prod_hi, prod_lo, flag_z, flag_c}));

    // R7: a fractional result always has a clear bit 0
    a_r7_frac_lsb_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (done && st_q.frac) |-> (prod_lo[0] == 1'b0));

    // R8: integer carry is the top product bit
    a_r8_int_carry_msb: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !st_q.frac) |-> (flag_c == prod_hi[W-1]));

    // R9: zero flag matches the delivered result in every format
    a_r9_zero_matches_result: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (flag_z == ({prod_hi, prod_lo} == '0)));

endmodule

// File: tb/mulx_unit_test.sv
`timescale 1ns/100ps
module mulx_unit_test;

    typedef struct {
        logic [15:0] prod;
        logic        z;
        logic        c;
        string       req;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [2:0] mode = '0;
    logic [7:0] op_a = '0;
    logic [7:0] op_b = '0;
    logic       done;
    logic [7:0] prod_lo, prod_hi;
    logic       flag_z, flag_c;

    int   total = 0;
    int   bad = 0;
    bit   finished = 0;
    exp_t sb[$];

    always #2.5 clk = ~clk;

    mulx_unit uut (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
        .op_a(op_a), .op_b(op_b), .done(done), .prod_lo(prod_lo),
        .prod_hi(prod_hi), .flag_z(flag_z), .flag_c(flag_c)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    // Reference model written from the requirements
    function automatic exp_t model(input logic [2:0] m, input logic [7:0] a,
                                   input logic [7:0] b, input string req);
        exp_t e;
        int   av, bv, p;
        logic [15:0] raw;
        av = (m[1:0] == 2'b01 || m[1:0] == 2'b10) ? int'($signed(a)) : int'(a);
        bv = (m[1:0] == 2'b01) ? int'($signed(b)) : int'(b);
        p = av * bv;
        raw = p[15:0];
        e.prod = m[2] ? {raw[14:0], 1'b0} : raw;
        e.c = raw[15];
        e.z = (e.prod == 16'h0);
        e.req = req;
        return e;
    endfunction

    task automatic issue(input logic [2:0] m, input logic [7:0] a,
                         input logic [7:0] b, input string req);
        @(negedge clk);
        start = 1'b1; mode = m; op_a = a; op_b = b;
        sb.push_back(model(m, a, b, req));
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            start = 1'b0;
        end
    endtask

    // Monitor: compare each result with the oldest expected item
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && done) begin
                if (sb.size() == 0) begin
                    check(0, "R2", "unexpected done", 1, 0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check({prod_hi, prod_lo} == e.prod, e.req, "product",
                          int'({prod_hi, prod_lo}), int'(e.prod));
                    check(flag_c == e.c, e.req, "carry", int'(flag_c), int'(e.c));
                    check(flag_z == e.z, e.req, "zero", int'(flag_z), int'(e.z));
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] held;
        logic [7:0]  lf;
        // R1: reset state
        repeat (3) @(negedge clk);
        check(done == 0, "R1", "done in reset", int'(done), 0);
        check({prod_hi, prod_lo} == 0, "R1", "product in reset",
              int'({prod_hi, prod_lo}), 0);
        check(flag_z == 0 && flag_c == 0, "R1", "flags in reset",
              int'({flag_z, flag_c}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(done == 0, "R1", "done after release", int'(done), 0);

        // R4 unsigned integer
        issue(3'b000, 8'd12, 8'd13, "R4");
        issue(3'b000, 8'hFF, 8'hFF, "R8");
        issue(3'b000, 8'h00, 8'h5A, "R8");
        issue(3'b000, 8'h80, 8'h02, "R8");
        // R5 signed×signed
        issue(3'b001, 8'hFF, 8'hFF, "R5");
        issue(3'b001, 8'h80, 8'h7F, "R5");
        issue(3'b001, 8'h80, 8'h80, "R5");
        issue(3'b001, 8'hFE, 8'h03, "R5");
        // R6 signed×unsigned
        issue(3'b010, 8'hFF, 8'hFF, "R6");
        issue(3'b010, 8'h7F, 8'hFF, "R6");
        issue(3'b010, 8'h80, 8'h01, "R6");
        // R7 / R9 fractional
        issue(3'b100, 8'hFF, 8'hFF, "R9");
        issue(3'b100, 8'h40, 8'h40, "R7");
        issue(3'b101, 8'hC0, 8'h40, "R7");
        issue(3'b110, 8'h80, 8'hFF, "R9");
        issue(3'b101, 8'h00, 8'h80, "R9");
        // R10 reserved code
        issue(3'b011, 8'hFF, 8'h80, "R10");
        issue(3'b111, 8'hF0, 8'h0F, "R10");
        // R11 corner
        issue(3'b101, 8'h80, 8'h80, "R11");
        idle(1);
        @(negedge clk);
        held = {prod_hi, prod_lo};
        check(held == 16'h8000, "R11", "wrap value", int'(held), 16'h8000);

        // R2 / R3: idle cycles
        idle(3);
        check(done == 0, "R2", "done while idle", int'(done), 0);
        check({prod_hi, prod_lo} == held, "R3", "hold while idle",
              int'({prod_hi, prod_lo}), int'(held));
        mode = 3'b000; op_a = 8'h11; op_b = 8'h22;
        @(negedge clk);
        check({prod_hi, prod_lo} == held, "R3", "inputs ignored without start",
              int'({prod_hi, prod_lo}), int'(held));

        // Sweep every mode with pseudo-random operands
        lf = 8'h5B;
        for (int k = 0; k < 200; k++) begin
            logic [7:0] x;
            lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
            x = lf ^ 8'(k * 37);
            issue(3'(k), lf, x, "R5");
        end
        idle(3);
        check(sb.size() == 0, "R2", "all results delivered", sb.size(), 0);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule